// File: doc/BRIEF.md
# Multi-drop 9-bit serial receiver with address wake-up

This block receives asynchronous serial frames that carry nine data bits. It is meant for a shared line on which one master talks to many slave nodes. Each frame has a low start bit, eight payload bits sent least significant bit first, a ninth bit and a high stop bit. A ninth bit of one marks an address frame, and the eight payload bits then hold the address. A ninth bit of zero marks a control or data frame.

An idle slave sets `addr_only_en`. With it set, only address frames are accepted and raise the receive flag, so software wakes only when an address passes on the line. Software then compares the address with its own. A slave that finds its address clears `addr_only_en`, and from then on every frame is delivered to it.

Accepted frames go into a holding register pair, and the sticky flag `rx_flag` is raised. Software reads the data and pulses `flag_clr` to release the holding register.

Top module: `mdrop_rx`

## Requirements
- R1: After reset, `rx_flag`, `rx_bit9` and `rx_data` are all zero.
- R2: Bits are timed in ticks of `os_tick`, 16 ticks per bit, and each bit is sampled at its middle. Payload bit 0 arrives first after the start bit and lands in `rx_data[0]`. The bit after the eighth payload bit lands in `rx_bit9`.
- R3: When `addr_only_en` is 1, a frame whose ninth bit is 0 is not accepted. `rx_flag` stays 0 and `rx_data`/`rx_bit9` keep their earlier values.
- R4: When `addr_only_en` is 1, a frame whose ninth bit is 1 is accepted and its payload is presented as the address.
- R5: When `addr_only_en` is 0, every well-formed frame is accepted, whatever its ninth bit.
- R6: On acceptance, `rx_data` and `rx_bit9` are loaded in the same clock cycle in which `rx_flag` rises. They change at no other time.
- R7: `rx_flag` stays 1 until `flag_clr` is sampled high. It is 0 one cycle after that.
- R8: A frame that completes while `rx_flag` is 1 is discarded. `rx_data` and `rx_bit9` are unchanged.
- R9: A low pulse on the line that is high again at the middle of the start bit is a false start. It produces no frame, and the next real frame is received correctly.
- R10: A frame whose stop bit samples low is discarded, with no flag and no change to the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_in | input | 1 | Serial line, idle high, asynchronous to `clk` |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| addr_only_en | input | 1 | 1: accept only frames with ninth bit set |
| flag_clr | input | 1 | Pulse to clear `rx_flag` |
| rx_data | output | 8 | Held payload byte of the last accepted frame |
| rx_bit9 | output | 1 | Held ninth bit of the last accepted frame |
| rx_flag | output | 1 | Sticky receive flag |

## Verification
The bench sweeps payload values across both wake-up settings and both ninth-bit values, with the tick running at half the clock rate.

Each corner case is aimed at a specific fault:
- A receiver that reversed the bit order, or dropped the ninth bit, would miscompare against the arithmetic model on almost every frame.
- A filter with the wake-up test inverted or missing would raise the flag on data frames while idle.
- Leaving frames unread checks the overrun rule. A design that let a later frame overwrite the holding register would lose the byte that was waiting to be read.
- Glitches shorter than half a bit, and frames with a low stop bit, catch a start detector that does not confirm at mid-bit and a framer that skips the stop check. Either fault would deliver phantom or misaligned bytes.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP
    } rx_state_e;

    function automatic bit wake_ok(input logic addr_only, input logic ninth);
        return (!addr_only) || ninth;
    endfunction

endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mdrop_rx_framer.sv
module mdrop_rx_framer
    import mdrop_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int FRAME_BITS = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  rxd,
    output logic                  done,
    output logic                  stop_ok,
    output logic [FRAME_BITS-1:0] frame
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int IW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVERSAMPLE - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(FRAME_BITS - 1);

    typedef struct packed {
        rx_state_e             st;
        logic [CW-1:0]         cnt;
        logic [IW-1:0]         idx;
        logic [FRAME_BITS-1:0] sh;
        logic                  done;
        logic                  stop_ok;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d         = fr_q;
        fr_d.done    = 1'b0;
        fr_d.stop_ok = 1'b0;
        case (fr_q.st)
            ST_IDLE: begin
                if (tick && !rxd) begin
                    fr_d.st  = ST_START;
                    fr_d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (fr_q.cnt == HALF_LAST) begin
                        fr_d.cnt = '0;
                        fr_d.idx = '0;
                        fr_d.st  = rxd ? ST_IDLE : ST_BITS;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            ST_BITS: begin
                if (tick) begin
                    if (fr_q.cnt == FULL_LAST) begin
                        fr_d.cnt = '0;
                        fr_d.sh  = {rxd, fr_q.sh[FRAME_BITS-1:1]};
                        if (fr_q.idx == IDX_LAST) fr_d.st  = ST_STOP;
                        else                      fr_d.idx = fr_q.idx + 1'b1;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (fr_q.cnt == FULL_LAST) begin
                        fr_d.cnt     = '0;
                        fr_d.done    = 1'b1;
                        fr_d.stop_ok = rxd;
                        fr_d.st      = ST_IDLE;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            default: fr_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q.st      <= ST_IDLE;
            fr_q.cnt     <= '0;
            fr_q.idx     <= '0;
            fr_q.sh      <= '0;
            fr_q.done    <= 1'b0;
            fr_q.stop_ok <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign done    = fr_q.done;
    assign stop_ok = fr_q.stop_ok;
    assign frame   = fr_q.sh;
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
    import mdrop_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic                 stop_ok,
    input  logic [DATA_BITS:0]   frame,
    input  logic                 addr_only,
    input  logic                 clr,
    output logic [DATA_BITS-1:0] data,
    output logic                 bit9,
    output logic                 flag
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 bit9;
        logic                 flag;
    } hold_t;

    hold_t h_d, h_q;
    logic  accept;

    always_comb begin
        accept = done && stop_ok && !h_q.flag
                 && wake_ok(addr_only, frame[DATA_BITS]);
        h_d = h_q;
        if (accept) begin
            h_d.data = frame[DATA_BITS-1:0];
            h_d.bit9 = frame[DATA_BITS];
            h_d.flag = 1'b1;
        end else if (clr) begin
            h_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign data = h_q.data;
    assign bit9 = h_q.bit9;
    assign flag = h_q.flag;
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd_in,
    input  logic                 os_tick,
    input  logic                 addr_only_en,
    input  logic                 flag_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_bit9,
    output logic                 rx_flag
);
    localparam int FRAME_BITS = DATA_BITS + 1;

    logic                  rxd_s;
    logic                  done_w;
    logic                  stop_ok_w;
    logic [FRAME_BITS-1:0] frame_w;

    mdrop_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd_in),
        .dout (rxd_s)
    );

    mdrop_rx_framer #(.OVERSAMPLE(OVERSAMPLE), .FRAME_BITS(FRAME_BITS)) framer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (os_tick),
        .rxd    (rxd_s),
        .done   (done_w),
        .stop_ok(stop_ok_w),
        .frame  (frame_w)
    );

    mdrop_rx_filter #(.DATA_BITS(DATA_BITS)) filter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done_w),
        .stop_ok  (stop_ok_w),
        .frame    (frame_w),
        .addr_only(addr_only_en),
        .clr      (flag_clr),
        .data     (rx_data),
        .bit9     (rx_bit9),
        .flag     (rx_flag)
    );
endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 addr_only_en,
    input logic                 flag_clr,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_bit9,
    input logic                 rx_flag,
    input logic                 frame_done
);
    AST_HOLD_ONLY_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_data != $past(rx_data)) || (rx_bit9 != $past(rx_bit9))) |-> $rose(rx_flag)); // R6

    AST_SET_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(frame_done)); // R2

    AST_ADDR_ONLY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_flag) && $past(addr_only_en)) |-> rx_bit9); // R3

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && rx_flag) |=> !rx_flag); // R7

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && $past(rx_flag)) |-> ($stable(rx_data) && $stable(rx_bit9))); // R8
endmodule

bind mdrop_rx mdrop_rx_chk #(.DATA_BITS(DATA_BITS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_only_en(addr_only_en),
    .flag_clr    (flag_clr),
    .rx_data     (rx_data),
    .rx_bit9     (rx_bit9),
    .rx_flag     (rx_flag),
    .frame_done  (done_w)
);

// File: tb/mdrop_rx_tb_top.sv
module mdrop_rx_tb_top;
    localparam int CLK_P   = 10;
    localparam int BIT_CYC = 32;   // 16 ticks, tick every 2nd cycle
    localparam int WDOG    = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd_in = 1'b1;
    logic       os_tick = 1'b0;
    logic       addr_only_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    logic [7:0] e_data = '0;
    logic       e_b9 = 1'b0;
    logic       e_flag = 1'b0;

    mdrop_rx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd_in      (rxd_in),
        .os_tick     (os_tick),
        .addr_only_en(addr_only_en),
        .flag_clr    (flag_clr),
        .rx_data     (rx_data),
        .rx_bit9     (rx_bit9),
        .rx_flag     (rx_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            os_tick = ~os_tick;
        end
    end

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {flag,bit9,data} actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic check_hold(input string req);
        check(req, {rx_flag, rx_bit9, rx_data}, {e_flag, e_b9, e_data});
    endtask

    task automatic hold_line(input logic v, input int cyc);
        rxd_in = v;
        repeat (cyc) @(negedge clk);
    endtask

    // stop_cyc: cycles the stop level is held before returning high
    task automatic send(input logic [7:0] d, input logic b9, input logic stop_v, input int stop_cyc);
        hold_line(1'b0, BIT_CYC);
        for (int i = 0; i < 8; i++) hold_line(d[i], BIT_CYC);
        hold_line(b9, BIT_CYC);
        hold_line(stop_v, stop_cyc);
        hold_line(1'b1, 60);
    endtask

    task automatic model(input logic [7:0] d, input logic b9, input logic stop_good);
        if (stop_good && !e_flag && (!addr_only_en || b9)) begin
            e_data = d;
            e_b9   = b9;
            e_flag = 1'b1;
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        e_flag = 1'b0;
        check("R7 clear", {rx_flag, rx_bit9, rx_data}, {1'b0, e_b9, e_data});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_hold("R1 reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_hold("R1 after release");

        // sweep: wake mode x ninth bit x payload
        for (int ao = 0; ao < 2; ao++) begin
            for (int b9 = 0; b9 < 2; b9++) begin
                for (int d = 0; d < 256; d += 11) begin
                    addr_only_en = ao[0];
                    send(d[7:0], b9[0], 1'b1, BIT_CYC);
                    model(d[7:0], b9[0], 1'b1);
                    if (ao == 1 && b9 == 0)      check_hold("R3 data frame filtered");
                    else if (ao == 1)            check_hold("R4 address frame accepted");
                    else                         check_hold("R5 all frames accepted / R2 order");
                    if (e_flag) clear_flag();
                end
            end
        end

        // R2: extreme payloads
        addr_only_en = 1'b0;
        send(8'h01, 1'b1, 1'b1, BIT_CYC); model(8'h01, 1'b1, 1'b1);
        check_hold("R2 lsb first");
        clear_flag();
        send(8'h80, 1'b0, 1'b1, BIT_CYC); model(8'h80, 1'b0, 1'b1);
        check_hold("R2 msb last");

        // R7: flag persists
        repeat (300) @(negedge clk);
        check_hold("R7 flag sticky");

        // R8: overrun while flag set
        send(8'h5A, 1'b1, 1'b1, BIT_CYC); model(8'h5A, 1'b1, 1'b1);
        check_hold("R8 overrun discarded");
        clear_flag();

        // R3: filtered frame leaves holding register
        addr_only_en = 1'b1;
        send(8'hC3, 1'b0, 1'b1, BIT_CYC); model(8'hC3, 1'b0, 1'b1);
        check_hold("R3 holding unchanged");

        // R9: false starts, then a real frame
        hold_line(1'b0, 6);
        hold_line(1'b1, 80);
        check_hold("R9 short glitch");
        hold_line(1'b0, 12);
        hold_line(1'b1, 80);
        check_hold("R9 longer glitch");
        send(8'hA5, 1'b1, 1'b1, BIT_CYC); model(8'hA5, 1'b1, 1'b1);
        check_hold("R9 frame after false start");
        clear_flag();

        // R10: bad stop bit
        addr_only_en = 1'b0;
        send(8'h3C, 1'b1, 1'b0, 20); model(8'h3C, 1'b1, 1'b0);
        check_hold("R10 framing error discarded");
        send(8'h77, 1'b0, 1'b1, BIT_CYC); model(8'h77, 1'b0, 1'b1);
        check_hold("R10 recovery");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(negedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule